// File: doc/BRIEF.md
# SPI Serial Memory Command Interface

This block is the serial front end of a small non-volatile memory. It watches a four-wire serial port (serial clock, active-low select, data in, data out) plus an active-low pause input, all oversampled on the chip's system clock. After the select line falls it gathers an 8-bit instruction, then an address byte and data bytes, and turns them into single-cycle requests to the neighbouring units. Write-enable changes and status-register writes go to the protection unit. Data-byte writes go to the page buffer sequencer, together with a commit strobe when the transaction closes on a byte boundary. Reads fetch bytes from an external behavioural array through a combinational address/data pair and shift them out most significant bit first.

The main array holds 128, 256 or 512 bytes, set by `MEM_BYTES`. A separate 16-byte identification page replaces the main array for a whole transaction when the page-select input is 0 at opcode time. The serial output pad is modelled as a data bit plus an output enable. The control is one state machine with eight states. `ST_IDLE` is the deselected state. `ST_OPCODE` collects the instruction. `ST_ADDR` collects the address. `ST_RD_DATA` streams array bytes. `ST_WR_DATA` accepts write bytes. `ST_SR_OUT` streams the status byte. `ST_SR_IN` accepts one status byte. `ST_DISCARD` swallows everything until deselect.

The transitions are:
- A select fall takes any state to `ST_OPCODE`.
- Select high takes any state to `ST_IDLE`.
- `ST_OPCODE` moves to `ST_SR_OUT`, `ST_SR_IN`, `ST_ADDR` or `ST_DISCARD` by the decoded instruction.
- `ST_ADDR` moves to `ST_RD_DATA` or `ST_WR_DATA`.
- `ST_SR_IN` moves to `ST_DISCARD` after its byte.

Top module: `smf_front`

## Requirements
- R1: A falling select starts a transaction and a rising select abandons it at any bit; `ser_dout_oe` is 0 whenever select has been high for two system-clock cycles.
- R2: Input bits are taken on rising serial-clock edges and `ser_dout` changes only after falling edges; a transaction works with the serial clock idling low (mode 0) or high (mode 3).
- R3: Instruction 0x06 produces one `wen_set` pulse and instruction 0x04 one `wen_clr` pulse, each right after the 8th instruction bit.
- R4: Instruction 0x05 shifts `status_byte` out MSB first, sampled again at the start of every output byte, for as long as the clock runs.
- R5: Instruction 0x01 takes the next byte and issues one `sreg_wr` pulse with it on `sreg_wdata`; any later bits are ignored.
- R6: Instruction 0x03 (bit 3 of the instruction carries address bit 8 when `MEM_BYTES` is 512, so 0x0B also reads) is followed by one address byte, then returns array bytes MSB first, incrementing the address and wrapping from the top of the array to 0.
- R7: When `main_sel` is 0 at instruction time, reads and writes of that transaction use the 16-byte identification page at address bits [3:0], wrapping from 15 to 0, with `rd_idpage`/`bw_idpage` set.
- R8: Instruction 0x02 (0x0A for bit 8 in the 512-byte size) with one address byte issues one `bw_valid` pulse per complete data byte at incrementing addresses; `bw_commit` pulses at deselect only if at least one byte arrived and no partial byte is pending.
- R9: Any other instruction value causes no request pulses and keeps `ser_dout_oe` at 0 until deselect.
- R10: While `wr_busy` is 1 at instruction time, only instruction 0x05 is executed; all others are treated as in R9.
- R11: A low `ser_pause_n` taken while the serial clock is low freezes the transfer and forces `ser_dout_oe` to 0; a high level taken while the clock is low resumes it with no bit lost; pause changes while the clock is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_sel_n | input | 1 | Active-low transaction select |
| ser_din | input | 1 | Serial data from the host |
| ser_pause_n | input | 1 | Active-low pause request |
| ser_dout | output | 1 | Serial data to the host |
| ser_dout_oe | output | 1 | Output enable for the serial data pad |
| wr_busy | input | 1 | Internal write cycle in progress |
| status_byte | input | 8 | Current status value returned by instruction 0x05 |
| main_sel | input | 1 | 1 selects the main array, 0 the identification page |
| wen_set | output | 1 | Pulse: enable writes |
| wen_clr | output | 1 | Pulse: disable writes |
| sreg_wr | output | 1 | Pulse: write status register |
| sreg_wdata | output | 8 | Status byte to write |
| bw_valid | output | 1 | Pulse: one write data byte received |
| bw_addr | output | ADDR_W | Address of the write byte |
| bw_data | output | 8 | Write data byte |
| bw_idpage | output | 1 | Write byte targets the identification page |
| bw_commit | output | 1 | Pulse: write transaction closed cleanly |
| rd_addr | output | ADDR_W | Read address to the array |
| rd_idpage | output | 1 | Read targets the identification page |
| rd_data | input | 8 | Combinational read data from the array |

## Verification
Two functions can meet in the same cycle. The first pair is the select rise and the decision on whether the last write byte was complete. The bench ends one write exactly after the 8th bit of a data byte and another four bits into a byte, then compares the queued write and commit pulses with those the monitor sees. The second pair is a pause request and a clock edge. The bench lowers the pause input while the clock is high and restores it before the clock falls, and also pauses with the clock low and runs four clock cycles through the pause. In both cases the byte reassembled from the output and the enable level must show that no bit was lost or added.

// File: rtl/smf_pkg.sv
package smf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_SR_OUT,
        ST_SR_IN,
        ST_DISCARD
    } smf_state_e;

    localparam logic [7:0] OP_WEN_SET = 8'h06;
    localparam logic [7:0] OP_WEN_CLR = 8'h04;
    localparam logic [7:0] OP_SR_READ = 8'h05;
    localparam logic [7:0] OP_SR_WRITE = 8'h01;
    localparam logic [7:0] OP_MEM_READ = 8'h03;
    localparam logic [7:0] OP_MEM_WRITE = 8'h02;

    localparam int ID_PAGE_BYTES = 16;
    localparam int ID_ADDR_W = $clog2(ID_PAGE_BYTES);
endpackage

// File: rtl/smf_pin_sampler.sv
module smf_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_clk,
    input  logic pin_sel_n,
    input  logic pin_din,
    input  logic pin_pause_n,
    output logic sel,
    output logic sel_fall,
    output logic sel_rise,
    output logic clk_rise,
    output logic clk_fall,
    output logic din_lvl,
    output logic paused
);
    logic clk_q, clk_qq, sel_n_q, sel_n_qq, din_q, pause_n_q, paused_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q     <= 1'b0;
            clk_qq    <= 1'b0;
            sel_n_q   <= 1'b1;
            sel_n_qq  <= 1'b1;
            din_q     <= 1'b0;
            pause_n_q <= 1'b1;
            paused_q  <= 1'b0;
        end else begin
            clk_q     <= pin_clk;
            clk_qq    <= clk_q;
            sel_n_q   <= pin_sel_n;
            sel_n_qq  <= sel_n_q;
            din_q     <= pin_din;
            pause_n_q <= pin_pause_n;
            if (sel_n_q)
                paused_q <= 1'b0;
            else if (!clk_q)
                paused_q <= ~pause_n_q;
        end
    end

    assign sel      = ~sel_n_q;
    assign sel_fall = ~sel_n_q & sel_n_qq;
    assign sel_rise = sel_n_q & ~sel_n_qq;
    assign clk_rise = clk_q & ~clk_qq & ~sel_n_q & ~paused_q;
    assign clk_fall = ~clk_q & clk_qq & ~sel_n_q & ~paused_q;
    assign din_lvl  = din_q;
    assign paused   = paused_q;
endmodule

// File: rtl/smf_rx_byte.sv
module smf_rx_byte #(
    parameter  int BITS = 8,
    localparam int CW   = $clog2(BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [BITS-1:0] data,
    output logic            done,
    output logic            at_boundary
);
    logic [BITS-2:0] sreg;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (shift_en) begin
            sreg <= {sreg[BITS-3:0], bit_in};
            cnt  <= (cnt == CW'(BITS - 1)) ? '0 : cnt + 1'b1;
        end
    end

    assign data        = {sreg, bit_in};
    assign done        = shift_en && (cnt == CW'(BITS - 1));
    assign at_boundary = (cnt == '0);
endmodule

// File: rtl/smf_tx_shift.sv
module smf_tx_shift #(
    parameter  int BITS = 8,
    localparam int CW   = $clog2(BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            shift_en,
    input  logic [BITS-1:0] load_val,
    output logic            take,
    output logic            serial_out,
    output logic            started
);
    logic [BITS-2:0] sreg;
    logic [CW-1:0]   cnt;

    assign take = shift_en && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg       <= '0;
            cnt        <= '0;
            serial_out <= 1'b0;
            started    <= 1'b0;
        end else if (clear) begin
            cnt     <= '0;
            started <= 1'b0;
        end else if (shift_en) begin
            started <= 1'b1;
            cnt     <= (cnt == CW'(BITS - 1)) ? '0 : cnt + 1'b1;
            if (cnt == '0) begin
                serial_out <= load_val[BITS-1];
                sreg       <= load_val[BITS-2:0];
            end else begin
                serial_out <= sreg[BITS-2];
                sreg       <= {sreg[BITS-3:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/smf_front.sv
module smf_front
    import smf_pkg::*;
#(
    parameter  int MEM_BYTES = 512,
    localparam int ADDR_W    = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_sel_n,
    input  logic              ser_din,
    input  logic              ser_pause_n,
    output logic              ser_dout,
    output logic              ser_dout_oe,
    input  logic              wr_busy,
    input  logic [7:0]        status_byte,
    input  logic              main_sel,
    output logic              wen_set,
    output logic              wen_clr,
    output logic              sreg_wr,
    output logic [7:0]        sreg_wdata,
    output logic              bw_valid,
    output logic [ADDR_W-1:0] bw_addr,
    output logic [7:0]        bw_data,
    output logic              bw_idpage,
    output logic              bw_commit,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_idpage,
    input  logic [7:0]        rd_data
);
    localparam logic [7:0] OPC_MASK = (MEM_BYTES > 256) ? 8'hF7 : 8'hFF;

    logic sel, sel_fall, sel_rise, clk_rise, clk_fall, din_lvl, hold_act;
    logic [7:0] rx_data;
    logic rx_done, rx_at_boundary;
    logic tx_shift, tx_take, tx_started, tx_bit;
    logic [7:0] tx_load;

    smf_state_e state_q, state_d, decode_st;
    logic [ADDR_W-1:0] addr_q, addr_next, addr_loaded;
    logic idp_q, is_wr_q, a8_q, got_byte_q;
    logic [7:0] opc_m;
    logic [8:0] full_addr;

    smf_pin_sampler u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_clk    (ser_clk),
        .pin_sel_n  (ser_sel_n),
        .pin_din    (ser_din),
        .pin_pause_n(ser_pause_n),
        .sel        (sel),
        .sel_fall   (sel_fall),
        .sel_rise   (sel_rise),
        .clk_rise   (clk_rise),
        .clk_fall   (clk_fall),
        .din_lvl    (din_lvl),
        .paused     (hold_act)
    );

    smf_rx_byte #(.BITS(8)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (sel_fall),
        .shift_en   (clk_rise),
        .bit_in     (din_lvl),
        .data       (rx_data),
        .done       (rx_done),
        .at_boundary(rx_at_boundary)
    );

    assign tx_shift = clk_fall && ((state_q == ST_RD_DATA) || (state_q == ST_SR_OUT));
    assign tx_load  = (state_q == ST_SR_OUT) ? status_byte : rd_data;

    smf_tx_shift #(.BITS(8)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sel_fall),
        .shift_en  (tx_shift),
        .load_val  (tx_load),
        .take      (tx_take),
        .serial_out(tx_bit),
        .started   (tx_started)
    );

    // Instruction decode and address arithmetic
    always_comb begin
        opc_m = rx_data & OPC_MASK;
        if (wr_busy) begin
            decode_st = (rx_data == OP_SR_READ) ? ST_SR_OUT : ST_DISCARD;
        end else if (rx_data == OP_SR_READ) begin
            decode_st = ST_SR_OUT;
        end else if (rx_data == OP_SR_WRITE) begin
            decode_st = ST_SR_IN;
        end else if ((opc_m == OP_MEM_READ) || (opc_m == OP_MEM_WRITE)) begin
            decode_st = ST_ADDR;
        end else begin
            decode_st = ST_DISCARD;
        end
        full_addr = {a8_q, rx_data};
        if (idp_q) begin
            addr_loaded = {{(ADDR_W-ID_ADDR_W){1'b0}}, rx_data[ID_ADDR_W-1:0]};
            addr_next   = {{(ADDR_W-ID_ADDR_W){1'b0}}, addr_q[ID_ADDR_W-1:0] + 1'b1};
        end else begin
            addr_loaded = full_addr[ADDR_W-1:0];
            addr_next   = addr_q + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!sel) begin
            state_d = ST_IDLE;
        end else if (sel_fall) begin
            state_d = ST_OPCODE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_OPCODE:  if (rx_done) state_d = decode_st;
                ST_ADDR:    if (rx_done) state_d = is_wr_q ? ST_WR_DATA : ST_RD_DATA;
                ST_SR_IN:   if (rx_done) state_d = ST_DISCARD;
                ST_RD_DATA: state_d = ST_RD_DATA;
                ST_WR_DATA: state_d = ST_WR_DATA;
                ST_SR_OUT:  state_d = ST_SR_OUT;
                ST_DISCARD: state_d = ST_DISCARD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            idp_q      <= 1'b0;
            is_wr_q    <= 1'b0;
            a8_q       <= 1'b0;
            got_byte_q <= 1'b0;
        end else begin
            if (sel_fall)
                got_byte_q <= 1'b0;
            if ((state_q == ST_OPCODE) && rx_done) begin
                is_wr_q <= (opc_m == OP_MEM_WRITE);
                a8_q    <= rx_data[3];
                idp_q   <= ~main_sel;
            end
            if ((state_q == ST_ADDR) && rx_done)
                addr_q <= addr_loaded;
            if ((state_q == ST_RD_DATA) && tx_take)
                addr_q <= addr_next;
            if ((state_q == ST_WR_DATA) && rx_done) begin
                addr_q     <= addr_next;
                got_byte_q <= 1'b1;
            end
        end
    end

    // Request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wen_set    <= 1'b0;
            wen_clr    <= 1'b0;
            sreg_wr    <= 1'b0;
            sreg_wdata <= '0;
            bw_valid   <= 1'b0;
            bw_addr    <= '0;
            bw_data    <= '0;
            bw_idpage  <= 1'b0;
            bw_commit  <= 1'b0;
        end else begin
            wen_set   <= (state_q == ST_OPCODE) && rx_done && !wr_busy && (rx_data == OP_WEN_SET);
            wen_clr   <= (state_q == ST_OPCODE) && rx_done && !wr_busy && (rx_data == OP_WEN_CLR);
            sreg_wr   <= (state_q == ST_SR_IN) && rx_done;
            bw_valid  <= (state_q == ST_WR_DATA) && rx_done;
            bw_commit <= sel_rise && (state_q == ST_WR_DATA) && got_byte_q && rx_at_boundary;
            if ((state_q == ST_SR_IN) && rx_done)
                sreg_wdata <= rx_data;
            if ((state_q == ST_WR_DATA) && rx_done) begin
                bw_addr   <= addr_q;
                bw_data   <= rx_data;
                bw_idpage <= idp_q;
            end
        end
    end

    assign ser_dout    = tx_bit;
    assign ser_dout_oe = sel && tx_started && !hold_act
                         && ((state_q == ST_RD_DATA) || (state_q == ST_SR_OUT));
    assign rd_addr     = addr_q;
    assign rd_idpage   = idp_q;
endmodule

// File: rtl/smf_front_chk.sv
module smf_front_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_sel_n,
    input logic              ser_dout,
    input logic              ser_dout_oe,
    input logic              wr_busy,
    input logic              wen_set,
    input logic              wen_clr,
    input logic              sreg_wr,
    input logic              bw_valid,
    input logic              bw_commit,
    input logic              bw_idpage,
    input logic [ADDR_W-1:0] bw_addr,
    input logic              tx_shift,
    input logic              hold_act
);
    AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sel_n && $past(ser_sel_n) |-> !ser_dout_oe); // R1

    AST_DOUT_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tx_shift) |-> $stable(ser_dout)); // R2

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wen_set, wen_clr, sreg_wr, bw_valid, bw_commit})); // R3

    AST_BUSY_BLOCKS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_set || wen_clr) |-> !$past(wr_busy)); // R10

    AST_IDPAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid && bw_idpage |-> (bw_addr < ADDR_W'(16))); // R7

    AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid |=> !bw_valid); // R8

    AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act && $past(hold_act) |-> $stable(ser_dout)); // R11
endmodule

bind smf_front smf_front_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_sel_n  (ser_sel_n),
    .ser_dout   (ser_dout),
    .ser_dout_oe(ser_dout_oe),
    .wr_busy    (wr_busy),
    .wen_set    (wen_set),
    .wen_clr    (wen_clr),
    .sreg_wr    (sreg_wr),
    .bw_valid   (bw_valid),
    .bw_commit  (bw_commit),
    .bw_idpage  (bw_idpage),
    .bw_addr    (bw_addr),
    .tx_shift   (tx_shift),
    .hold_act   (hold_act)
);

// File: tb/smf_front_tb.sv
module smf_front_tb;
    localparam int MEM_BYTES = 512;
    localparam int AW = 9;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_sel_n = 1'b1, ser_din = 1'b0, ser_pause_n = 1'b1;
    logic ser_dout, ser_dout_oe;
    logic wr_busy = 1'b0, main_sel = 1'b1;
    logic [7:0] status_byte = 8'h00;
    logic wen_set, wen_clr, sreg_wr, bw_valid, bw_idpage, bw_commit, rd_idpage;
    logic [7:0] sreg_wdata, bw_data, rd_data;
    logic [AW-1:0] bw_addr, rd_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic mode3 = 1'b0;
    logic [20:0] exp_q[$];

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_model(logic idp, logic [AW-1:0] a);
        return idp ? (8'hC0 | {4'h0, a[3:0]}) : (a[7:0] ^ {a[8], 7'h2B});
    endfunction

    assign rd_data = mem_model(rd_idpage, rd_addr);

    smf_front #(.MEM_BYTES(MEM_BYTES)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk(ser_clk), .ser_sel_n(ser_sel_n), .ser_din(ser_din), .ser_pause_n(ser_pause_n),
        .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
        .wr_busy(wr_busy), .status_byte(status_byte), .main_sel(main_sel),
        .wen_set(wen_set), .wen_clr(wen_clr), .sreg_wr(sreg_wr), .sreg_wdata(sreg_wdata),
        .bw_valid(bw_valid), .bw_addr(bw_addr), .bw_data(bw_data), .bw_idpage(bw_idpage),
        .bw_commit(bw_commit), .rd_addr(rd_addr), .rd_idpage(rd_idpage), .rd_data(rd_data)
    );

    // kinds: 1 write enable, 2 write disable, 3 status write, 4 data write, 5 commit
    function automatic logic [20:0] mk_ev(int kind, logic idp, logic [8:0] a, logic [7:0] d);
        return {3'(kind), idp, a, d};
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic take(logic [20:0] got);
        string req;
        case (got[20:18])
            3'd1, 3'd2: req = "R3 request";
            3'd3:       req = "R5 status write";
            default:    req = "R8 write request";
        endcase
        if (exp_q.size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 unexpected request actual=%0h expected=none", got);
        end else begin
            check(req, int'(got), int'(exp_q.pop_front()));
        end
    endtask

    // Monitor: pops the scoreboard as requests appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (wen_set)   take(mk_ev(1, 1'b0, 9'h0, 8'h0));
            if (wen_clr)   take(mk_ev(2, 1'b0, 9'h0, 8'h0));
            if (sreg_wr)   take(mk_ev(3, 1'b0, 9'h0, sreg_wdata));
            if (bw_valid)  take(mk_ev(4, bw_idpage, bw_addr, bw_data));
            if (bw_commit) take(mk_ev(5, 1'b0, 9'h0, 8'h0));
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cs_start();
        ser_clk = mode3;
        tick(H);
        ser_sel_n = 1'b0;
        tick(H);
    endtask

    task automatic cs_end();
        if (!mode3) ser_clk = 1'b0;
        tick(H);
        ser_sel_n = 1'b1;
        tick(2 * H);
    endtask

    task automatic xbit(input logic b, output logic o, output logic oe);
        ser_clk = 1'b0;
        ser_din = b;
        tick(H);
        o  = ser_dout;
        oe = ser_dout_oe;
        ser_clk = 1'b1;
        tick(H);
    endtask

    task automatic xbyte(input logic [7:0] t, output logic [7:0] r,
                         output logic oe_all, output logic oe_any);
        logic o, oe;
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            xbit(t[i], o, oe);
            r[i] = o;
            oe_all &= oe;
            oe_any |= oe;
        end
    endtask

    task automatic drained(string req);
        check(req, exp_q.size(), 0);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic oa, on, o, oe;
        tick(4);
        check("R1 reset output enable", ser_dout_oe, 0);
        rst_n = 1'b1;
        tick(4);

        // R3 write enable / disable
        exp_q.push_back(mk_ev(1, 1'b0, 9'h0, 8'h0));
        cs_start(); xbyte(8'h06, r, oa, on); cs_end();
        drained("R3 enable pulse");
        exp_q.push_back(mk_ev(2, 1'b0, 9'h0, 8'h0));
        cs_start(); xbyte(8'h04, r, oa, on); cs_end();
        drained("R3 disable pulse");

        // R1 abort mid-instruction: only the following disable counts
        cs_start();
        for (int i = 7; i >= 4; i--) xbit(1'(8'h06 >> i), o, oe);
        cs_end();
        exp_q.push_back(mk_ev(2, 1'b0, 9'h0, 8'h0));
        cs_start(); xbyte(8'h04, r, oa, on); cs_end();
        drained("R1 aborted instruction");

        // R4 status read, repeated
        status_byte = 8'hA6;
        cs_start(); xbyte(8'h05, r, oa, on);
        xbyte(8'h00, r, oa, on);
        check("R4 status byte 1", r, 8'hA6);
        check("R4 output enabled", oa, 1);
        status_byte = 8'h3C;
        xbyte(8'h00, r, oa, on);
        check("R4 status byte 2", r, 8'h3C);
        cs_end();
        check("R1 output off after deselect", ser_dout_oe, 0);

        // R5 status write, extra byte ignored
        exp_q.push_back(mk_ev(3, 1'b0, 9'h0, 8'h8C));
        cs_start(); xbyte(8'h01, r, oa, on); xbyte(8'h8C, r, oa, on);
        xbyte(8'hFF, r, oa, on); cs_end();
        drained("R5 single status write");

        // R6 read with increment; bit 8 via instruction bit 3 and wrap
        cs_start(); xbyte(8'h03, r, oa, on); xbyte(8'h10, r, oa, on);
        for (int k = 0; k < 3; k++) begin
            xbyte(8'h00, r, oa, on);
            check("R6 read increment", r, mem_model(1'b0, 9'(9'h010 + k)));
        end
        cs_end();
        cs_start(); xbyte(8'h0B, r, oa, on); xbyte(8'hFE, r, oa, on);
        xbyte(8'h00, r, oa, on); check("R6 read 0x1FE", r, mem_model(1'b0, 9'h1FE));
        xbyte(8'h00, r, oa, on); check("R6 read 0x1FF", r, mem_model(1'b0, 9'h1FF));
        xbyte(8'h00, r, oa, on); check("R6 wrap to 0", r, mem_model(1'b0, 9'h000));
        cs_end();

        // R7 identification page read wraps at 15
        main_sel = 1'b0;
        cs_start(); xbyte(8'h03, r, oa, on); xbyte(8'h0E, r, oa, on);
        xbyte(8'h00, r, oa, on); check("R7 id byte 14", r, mem_model(1'b1, 9'h00E));
        xbyte(8'h00, r, oa, on); check("R7 id byte 15", r, mem_model(1'b1, 9'h00F));
        xbyte(8'h00, r, oa, on); check("R7 id wrap", r, mem_model(1'b1, 9'h000));
        cs_end();

        // R7 identification page write wraps
        exp_q.push_back(mk_ev(4, 1'b1, 9'h00F, 8'h44));
        exp_q.push_back(mk_ev(4, 1'b1, 9'h000, 8'h55));
        exp_q.push_back(mk_ev(5, 1'b0, 9'h0, 8'h0));
        cs_start(); xbyte(8'h02, r, oa, on); xbyte(8'h3F, r, oa, on);
        xbyte(8'h44, r, oa, on); xbyte(8'h55, r, oa, on); cs_end();
        drained("R7 id page write");
        main_sel = 1'b1;

        // R8 write with commit, bit 8 set through 0x0A
        exp_q.push_back(mk_ev(4, 1'b0, 9'h120, 8'h11));
        exp_q.push_back(mk_ev(4, 1'b0, 9'h121, 8'h22));
        exp_q.push_back(mk_ev(5, 1'b0, 9'h0, 8'h0));
        cs_start(); xbyte(8'h0A, r, oa, on); xbyte(8'h20, r, oa, on);
        xbyte(8'h11, r, oa, on); xbyte(8'h22, r, oa, on); cs_end();
        drained("R8 write and commit");

        // R8 partial trailing byte: no commit
        exp_q.push_back(mk_ev(4, 1'b0, 9'h005, 8'h33));
        cs_start(); xbyte(8'h02, r, oa, on); xbyte(8'h05, r, oa, on);
        xbyte(8'h33, r, oa, on);
        for (int i = 0; i < 4; i++) xbit(1'b1, o, oe);
        cs_end();
        drained("R8 partial byte no commit");

        // R9 unknown instruction
        cs_start(); xbyte(8'h07, r, oa, on);
        begin
            logic any = on;
            xbyte(8'h03, r, oa, on); any |= on;
            xbyte(8'h00, r, oa, on); any |= on;
            xbyte(8'h00, r, oa, on); any |= on;
            check("R9 output stays off", any, 0);
        end
        cs_end();
        drained("R9 no requests");

        // R10 busy: only status read runs
        wr_busy = 1'b1;
        status_byte = 8'h81;
        cs_start(); xbyte(8'h06, r, oa, on); cs_end();
        cs_start(); xbyte(8'h02, r, oa, on); xbyte(8'h00, r, oa, on);
        xbyte(8'hAA, r, oa, on); cs_end();
        drained("R10 busy blocks commands");
        cs_start(); xbyte(8'h05, r, oa, on); xbyte(8'h00, r, oa, on); cs_end();
        check("R10 status read while busy", r, 8'h81);
        wr_busy = 1'b0;

        // R11 pause with clock low, then pause glitch with clock high
        cs_start(); xbyte(8'h03, r, oa, on); xbyte(8'h40, r, oa, on);
        for (int i = 7; i >= 5; i--) begin xbit(1'b0, o, oe); r[i] = o; end
        ser_clk = 1'b0; tick(H);
        ser_pause_n = 1'b0; tick(H);
        check("R11 output off while paused", ser_dout_oe, 0);
        repeat (4) begin ser_clk = 1'b1; tick(H); ser_clk = 1'b0; tick(H); end
        ser_pause_n = 1'b1; tick(H);
        for (int i = 4; i >= 0; i--) begin xbit(1'b0, o, oe); r[i] = o; end
        check("R11 byte intact across pause", r, mem_model(1'b0, 9'h040));
        oa = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            xbit(1'b0, o, oe); r[i] = o; oa &= oe;
            if (i == 7) begin
                ser_pause_n = 1'b0; tick(2);
                ser_pause_n = 1'b1; tick(3);
            end
        end
        check("R11 pause while clock high ignored", r, mem_model(1'b0, 9'h041));
        check("R11 output kept on", oa, 1);
        cs_end();

        // R2 mode 3: clock idles high
        mode3 = 1'b1;
        status_byte = 8'h5C;
        cs_start(); xbyte(8'h05, r, oa, on); xbyte(8'h00, r, oa, on); cs_end();
        check("R2 mode 3 status read", r, 8'h5C);
        cs_start(); xbyte(8'h0B, r, oa, on); xbyte(8'hA3, r, oa, on);
        xbyte(8'h00, r, oa, on); cs_end();
        check("R2 mode 3 array read", r, mem_model(1'b0, 9'h1A3));
        check("R1 output off after mode 3", ser_dout_oe, 0);
        mode3 = 1'b0;

        tick(10);
        drained("R8 scoreboard empty");
        report();
        $finish;
    end
endmodule